// File: doc/BRIEF.md
# Bridge and High-Side Gate Command Generator with Overload Softstart

This block turns a set of register control bits into gate-enable commands. It drives three half bridges, each with a high-side and a low-side switch, and three stand-alone high-side switches. Each of the six outputs can be gated by one of two external PWM pins. A half bridge never has both of its switches on at once. When a bridge changes from one side to the other, the newly selected side stays off until a programmable number of 1 µs ticks has passed with both switches off.

The block also handles tripped switches. An over-current flag turns its switch off. If recovery is disabled for that output, the switch stays off until software clears the flag. If recovery is enabled, the switch is turned back on for a short window in every recovery period. The window is about one eighth or one quarter of the period, chosen by a single control bit. This lets lamps, heaters and motors with a large inrush current start without being shut down for good.

A global disable input covers thermal, supply and standby shutdown. It forces every command low in the same cycle and restarts the dead-time wait of every bridge. All pins are plain control levels, so there is no valid/ready handshake and no back-pressure.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with all commands clear, every bit of `en_out` is 0. After reset, both switches of every bridge may turn on without a dead-time wait.
- R2: `en_out` is indexed as follows: bits 0..2 are the high sides of bridges 0..2, bits 3..5 are the low sides of bridges 0..2, and bits 6..8 are the stand-alone high-side switches. The outputs are numbered 0..5 (bridges first, then the stand-alone switches). The gate of an output is its command bit ANDed with its selected PWM pin when its `pwm_sel` bit is 1, and the command bit alone when its `pwm_sel` bit is 0. Output 4 uses `pwm_in[1]`. All other outputs use `pwm_in[0]`. A change in the gate appears on `en_out` one clock later.
- R3: When both the high-side and the low-side commands of a bridge are set, both of its switches are off one clock later and stay off. No two switches of one bridge are ever on together.
- R4: After one side of a bridge turns off, the other side turns on only once `DT_TICKS` ticks have been counted while both sides were off. With a tick in every cycle, the new side turns on at the (`DT_TICKS`+2)-th clock edge after the command change.
- R5: A side that switches off and is requested again, with no turn-on of the opposite side in between, comes back on one clock later with no dead-time wait.
- R6: One clock after a switch's `oc_flag` rises, that switch is off, whatever its recovery setting. With recovery disabled, it stays off for as long as the flag is high. Once the flag is cleared, the switch follows its command again one clock later.
- R7: While the flag is high and recovery is enabled, the switch is on for exactly `ON_LO` ticks (`duty_hi`=0) or `ON_HI` ticks (`duty_hi`=1) in every `PERIOD` ticks. Each window starts at a period boundary of a free-running phase counter.
- R8: The recovery-enable bit is sampled at each period boundary. Clearing it partway through a window lets that window run to its full length, and no later window follows.
- R9: While `glob_off` is high, `en_out` is all zero in the same cycle. After `glob_off` falls, a stand-alone switch follows its command one clock later. A bridge side waits `DT_TICKS` ticks, which is `DT_TICKS`+1 edges with a tick in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| glob_off | input | 1 | Global disable (thermal, supply, standby) |
| br_hs_cmd | input | NB | High-side on command per bridge |
| br_ls_cmd | input | NB | Low-side on command per bridge |
| hso_cmd | input | NH | On command per stand-alone high-side switch |
| pwm_sel | input | NB+NH | Per-output PWM gating enable |
| pwm_in | input | 2 | External PWM pins |
| duty_hi | input | 1 | Recovery duty select: 0 short window, 1 long window |
| rec_en | input | NB+NH | Per-output over-current recovery enable |
| oc_flag | input | 2*NB+NH | Per-switch qualified over-current status |
| en_out | output | 2*NB+NH | Per-switch gate enable |

## Verification
Command, PWM and over-current changes are due on `en_out` one clock after the inputs change. A global disable takes effect in the same cycle. With the tick held high, an opposite-side turn-on is due at edge `DT_TICKS`+2, or at edge `DT_TICKS`+1 after a disable is released. The bench drives its inputs on falling edges. It samples at the falling edge of the exact edge count it expects, and checks both the edge just before the turn-on and the edge of the turn-on itself. The recovery duty is not tied to a phase. It is checked by counting the on-cycles over three whole periods, after waiting at least one boundary, so the result does not depend on where the free-running phase stood.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;
  // last side of a bridge that was driven on
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HI   = 2'd1,
    SIDE_LO   = 2'd2
  } side_e;
endpackage

// File: rtl/hbg_rec_timer.sv
`timescale 1ns/1ps
// Free-running recovery phase: boundary pulse and on-window flag
module hbg_rec_timer #(
  parameter int PERIOD = 333,
  parameter int ON_LO  = 40,
  parameter int ON_HI  = 83
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic duty_hi,
  output logic wrap,
  output logic in_on
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST  = PW'(PERIOD - 1);
  localparam logic [PW-1:0] LIM_L = PW'(ON_LO);
  localparam logic [PW-1:0] LIM_H = PW'(ON_HI);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (tick)
      phase <= (phase == LAST) ? '0 : phase + PW'(1);
  end

  assign wrap  = tick && (phase == LAST);
  assign in_on = duty_hi ? (phase < LIM_H) : (phase < LIM_L);
endmodule

// File: rtl/hbg_oc_gate.sv
`timescale 1ns/1ps
// Per-switch over-current permission with recovery windows
module hbg_oc_gate #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic         in_on,
  input  logic [N-1:0] oc,
  input  logic [N-1:0] rec,
  output logic [N-1:0] allow
);
  // armed for recovery; set only at a period boundary
  logic [N-1:0] act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act <= '0;
    else if (wrap)
      act <= oc & rec;
    else
      act <= act & oc;
  end

  assign allow = ~oc | (act & {N{in_on}});
endmodule

// File: rtl/hbg_bridge.sv
`timescale 1ns/1ps
// One half bridge: conflict blocking and dead time between sides
module hbg_bridge
  import hbg_pkg::*;
#(
  parameter int DT = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic kill,
  input  logic req_hi,
  input  logic req_lo,
  output logic en_hi,
  output logic en_lo
);
  localparam int DW = (DT > 0) ? $clog2(DT + 1) : 1;
  localparam logic [DW-1:0] GAP_END = DW'(DT);

  logic [DW-1:0] gap;
  side_e         last;
  logic          gap_done, go_hi, go_lo;

  assign gap_done = (gap == GAP_END);
  assign go_hi = req_hi && !req_lo && !en_lo && (gap_done || last == SIDE_HI);
  assign go_lo = req_lo && !req_hi && !en_hi && (gap_done || last == SIDE_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_hi <= 1'b0;
      en_lo <= 1'b0;
      gap   <= GAP_END;
      last  <= SIDE_NONE;
    end else if (kill) begin
      en_hi <= 1'b0;
      en_lo <= 1'b0;
      gap   <= '0;
      last  <= SIDE_NONE;
    end else begin
      en_hi <= go_hi;
      en_lo <= go_lo;
      if (en_hi || en_lo)
        gap <= '0;
      else if (tick && !gap_done)
        gap <= gap + DW'(1);
      if (go_hi)
        last <= SIDE_HI;
      else if (go_lo)
        last <= SIDE_LO;
    end
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
`timescale 1ns/1ps
module hb_gate_ctrl #(
  parameter int          NB        = 3,
  parameter int          NH        = 3,
  parameter int          PERIOD    = 333,
  parameter int          ON_LO     = 40,
  parameter int          ON_HI     = 83,
  parameter int          DT_TICKS  = 300,
  parameter logic [31:0] PIN2_MASK = 32'h0000_0010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1us,
  input  logic                glob_off,
  input  logic [NB-1:0]       br_hs_cmd,
  input  logic [NB-1:0]       br_ls_cmd,
  input  logic [NH-1:0]       hso_cmd,
  input  logic [NB+NH-1:0]    pwm_sel,
  input  logic [1:0]          pwm_in,
  input  logic                duty_hi,
  input  logic [NB+NH-1:0]    rec_en,
  input  logic [2*NB+NH-1:0]  oc_flag,
  output logic [2*NB+NH-1:0]  en_out
);
  localparam int NOUT = NB + NH;
  localparam int NSW  = 2 * NB + NH;

  logic [NOUT-1:0] gate;
  logic [NSW-1:0]  cmd_sw, gate_sw, rec_sw, allow, req_sw;
  logic [NB-1:0]   br_hi, br_lo;
  logic [NH-1:0]   hso_q;
  logic            wrap, in_on;

  // per-output PWM gating, pin picked by mask
  for (genvar o = 0; o < NOUT; o++) begin : g_gate
    assign gate[o] = pwm_sel[o] ? (PIN2_MASK[o] ? pwm_in[1] : pwm_in[0]) : 1'b1;
  end

  assign cmd_sw = {hso_cmd, br_ls_cmd, br_hs_cmd};

  // map each switch to its output number
  for (genvar s = 0; s < NSW; s++) begin : g_map
    localparam int O = (s < NB) ? s : s - NB;
    assign gate_sw[s] = gate[O];
    assign rec_sw[s]  = rec_en[O];
  end

  hbg_rec_timer #(.PERIOD(PERIOD), .ON_LO(ON_LO), .ON_HI(ON_HI)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_1us), .duty_hi(duty_hi),
    .wrap(wrap), .in_on(in_on)
  );

  hbg_oc_gate #(.N(NSW)) u_ocg (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .in_on(in_on),
    .oc(oc_flag), .rec(rec_sw), .allow(allow)
  );

  assign req_sw = cmd_sw & gate_sw & allow;

  for (genvar b = 0; b < NB; b++) begin : g_br
    hbg_bridge #(.DT(DT_TICKS)) u_br (
      .clk(clk), .rst_n(rst_n), .tick(tick_1us), .kill(glob_off),
      .req_hi(req_sw[b]), .req_lo(req_sw[NB+b]),
      .en_hi(br_hi[b]), .en_lo(br_lo[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hso_q <= '0;
    else if (glob_off)
      hso_q <= '0;
    else
      hso_q <= req_sw[2*NB +: NH];
  end

  assign en_out = {hso_q, br_lo, br_hi} & {NSW{~glob_off}};
endmodule

// File: rtl/hbg_checker.sv
`timescale 1ns/1ps
module hbg_checker #(
  parameter int NB = 3,
  parameter int NH = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glob_off,
  input logic [NH-1:0]      hso_cmd,
  input logic [2*NB+NH-1:0] oc_flag,
  input logic [2*NB+NH-1:0] en_out
);
  localparam int NSW = 2 * NB + NH;

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (en_out == '0);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_br
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_out[b] && en_out[NB+b]));
    assert_gap_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_out[b]) |-> !$past(en_out[NB+b]));
    assert_gap_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_out[NB+b]) |-> !$past(en_out[b]));
  end

  for (genvar s = 0; s < NSW; s++) begin : g_sw
    assert_trip_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oc_flag[s]) |=> !en_out[s]);
  end

  for (genvar h = 0; h < NH; h++) begin : g_hs
    assert_cmd_needed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en_out[2*NB+h] |-> $past(hso_cmd[h]));
  end

  assert_global_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    glob_off |-> (en_out == '0));
endmodule

bind hb_gate_ctrl hbg_checker #(.NB(NB), .NH(NH)) u_hbg_checker (
  .clk(clk), .rst_n(rst_n), .glob_off(glob_off), .hso_cmd(hso_cmd),
  .oc_flag(oc_flag), .en_out(en_out)
);

// File: tb/test_hb_gate_ctrl.sv
`timescale 1ns/1ps
module test_hb_gate_ctrl;
  localparam int NB = 3, NH = 3, NSW = 9;
  localparam int PER = 16, ONL = 2, ONH = 4, DT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic tick = 1'b1;
  logic glob_off = 1'b0;
  logic [NB-1:0] br_hs_cmd = '0, br_ls_cmd = '0;
  logic [NH-1:0] hso_cmd = '0;
  logic [5:0] pwm_sel = '0, rec_en = '0;
  logic [1:0] pwm_in = '0;
  logic duty_hi = 1'b0;
  logic [NSW-1:0] oc_flag = '0;
  logic [NSW-1:0] en_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hb_gate_ctrl #(.NB(NB), .NH(NH), .PERIOD(PER), .ON_LO(ONL), .ON_HI(ONH),
                 .DT_TICKS(DT), .PIN2_MASK(32'h10)) i_hb_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick), .glob_off(glob_off),
    .br_hs_cmd(br_hs_cmd), .br_ls_cmd(br_ls_cmd), .hso_cmd(hso_cmd),
    .pwm_sel(pwm_sel), .pwm_in(pwm_in), .duty_hi(duty_hi), .rec_en(rec_en),
    .oc_flag(oc_flag), .en_out(en_out)
  );

  task automatic chk(input string req, input logic [NSW-1:0] act, input logic [NSW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_n(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_on(input int s, input int n, output int ones);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (en_out[s]) ones++;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int ones;
    logic [NSW-1:0] e;
    logic prev;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", en_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", en_out, '0);

    // R2: sweep commands, gating selects and pin levels
    for (int v = 0; v < 256; v++) begin
      hso_cmd   = v[2:0];
      br_hs_cmd = v[2:0];
      pwm_sel   = {v[5:3], v[5:3]};
      pwm_in    = v[7:6];
      @(negedge clk);
      e = '0;
      for (int o = 0; o < 6; o++) begin
        logic c, sl, pn, g;
        c  = v[o % 3];
        sl = v[3 + o % 3];
        pn = (o == 4) ? v[7] : v[6];
        g  = c & (sl ? pn : 1'b1);
        if (o < 3) e[o] = g; else e[6 + o - 3] = g;
      end
      chk("R2 pwm gating", en_out, e);
    end
    hso_cmd = '0; br_hs_cmd = '0; pwm_sel = '0; pwm_in = '0;
    repeat (10) @(negedge clk);
    chk("R2 all off", en_out, '0);

    // R4: dead time low -> high on bridge 1
    br_ls_cmd[1] = 1'b1;
    @(negedge clk);
    chk("R4 low side on", en_out, 9'b000010000);
    br_ls_cmd[1] = 1'b0; br_hs_cmd[1] = 1'b1;
    for (int n = 1; n <= DT + 2; n++) begin
      @(negedge clk);
      chk("R4 lo->hi dead time", en_out, (n >= DT + 2) ? 9'b000000010 : 9'b0);
    end
    // R4: high -> low
    br_hs_cmd[1] = 1'b0; br_ls_cmd[1] = 1'b1;
    for (int n = 1; n <= DT + 2; n++) begin
      @(negedge clk);
      chk("R4 hi->lo dead time", en_out, (n >= DT + 2) ? 9'b000010000 : 9'b0);
    end

    // R5: same side back on without wait
    br_ls_cmd[1] = 1'b0;
    @(negedge clk);
    chk("R5 side off", en_out, '0);
    br_ls_cmd[1] = 1'b1;
    @(negedge clk);
    chk("R5 same side immediate", en_out, 9'b000010000);

    // R3: both commands set
    br_hs_cmd[1] = 1'b1;
    @(negedge clk);
    chk("R3 conflict off", en_out, '0);
    repeat (10) @(negedge clk);
    chk("R3 conflict stays off", en_out, '0);
    br_hs_cmd[1] = 1'b0; br_ls_cmd[1] = 1'b0;
    repeat (10) @(negedge clk);

    // R6: trip without recovery on stand-alone switch 6
    hso_cmd[0] = 1'b1;
    @(negedge clk);
    chk("R6 switch on", en_out, 9'b001000000);
    oc_flag[6] = 1'b1;
    @(negedge clk);
    chk("R6 tripped off", en_out, '0);
    count_on(6, 3 * PER, ones);
    chk_n("R6 stays off without recovery", ones, 0);
    oc_flag[6] = 1'b0;
    @(negedge clk);
    chk("R6 back on after clear", en_out, 9'b001000000);

    // R7: recovery windows
    rec_en[3] = 1'b1; oc_flag[6] = 1'b1;
    @(negedge clk);
    chk("R6 off after trip with recovery", en_out, '0);
    repeat (2 * PER) @(negedge clk);
    count_on(6, 3 * PER, ones);
    chk_n("R7 short duty count", ones, 3 * ONL);
    duty_hi = 1'b1;
    repeat (PER) @(negedge clk);
    count_on(6, 3 * PER, ones);
    chk_n("R7 long duty count", ones, 3 * ONH);

    // R8: clear enable at window start
    prev = en_out[6];
    for (int i = 0; i < 2 * PER; i++) begin
      @(negedge clk);
      if (en_out[6] && !prev) break;
      prev = en_out[6];
    end
    rec_en[3] = 1'b0;
    ones = 1;
    for (int i = 0; i < PER - 1; i++) begin
      @(negedge clk);
      if (en_out[6]) ones++;
    end
    chk_n("R8 window completes", ones, ONH);
    count_on(6, 2 * PER, ones);
    chk_n("R8 no further window", ones, 0);
    oc_flag[6] = 1'b0; hso_cmd[0] = 1'b0; duty_hi = 1'b0;
    repeat (10) @(negedge clk);

    // R9: global disable
    hso_cmd[1] = 1'b1; br_hs_cmd[2] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 before disable", en_out, 9'b010000100);
    glob_off = 1'b1;
    #2;
    chk("R9 same cycle zero", en_out, '0);
    @(negedge clk);
    chk("R9 held zero", en_out, '0);
    glob_off = 1'b0;
    for (int n = 1; n <= DT + 1; n++) begin
      @(negedge clk);
      chk("R9 release", en_out, (n >= DT + 1) ? 9'b010000100 : 9'b010000000);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule